// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave side of a serial flash interface. It takes a four-wire serial bus plus a pause line and turns command frames into read traffic. A frame opens with an eight-bit opcode. Some opcodes are followed by a three-byte address, sent most significant byte first, and some also by one don't-care byte. After that the block streams bytes out until chip select goes high. The bytes come from a small registered memory array, from a status source, or from fixed identification constants. The block also tracks a deep-sleep state. While asleep it accepts only the wake opcode, and the wake-up completes after a programmable number of clocks.

The serial pins are oversampled by the block's own clock. The bus clock is edge-detected, so both clock polarities work: idle low (mode 0) and idle high (mode 3). Input bits are taken on bus-clock rising edges and output bits change on falling edges. Each byte is fetched one byte ahead, so the next byte's first bit is ready at the next falling edge.

Top module: `spf_front`

## Requirements
- R1: Input bits are sampled on rising bus-clock edges and output bits change on falling edges. Frames work whether the bus clock idles low or idles high when select falls.
- R2: Opcode 03h followed by a 3-byte address starts a single-bit stream on io_out[1]. The bytes come from array addresses taken from the low MEM_AW address bits. The address increments per byte and wraps from 2^MEM_AW-1 back to 0.
- R3: Opcode 0Bh behaves as 03h, except that one extra don't-care byte follows the address before data starts.
- R4: Opcode 3Bh takes an address and one don't-care byte, then drives two bits per bus clock. io_out[1] carries bits 7,5,3,1 and io_out[0] carries bits 6,4,2,0, and io_oe is 2'b11.
- R5: Opcode 9Fh, with no address, streams 8Ch, 30h, 13h and then repeats from 8Ch.
- R6: Opcode 90h with an address streams alternating 8Ch and 12h. The stream starts with 8Ch when address bit 0 is 0 and with 12h when it is 1.
- R7: Opcode 05h streams the stat_rdata byte repeatedly. stat_req pulses once for each byte, issued one byte ahead: at the header end and at the last bit of each byte.
- R8: Opcode B9h sets power_down when select next rises. While power_down is high, every opcode other than ABh is ignored: io_oe stays 2'b00 and mem_req stays low.
- R9: Opcode ABh clears power_down between WAKE_CYCLES and WAKE_CYCLES+2 clocks after select rises. When ABh is followed by three don't-care bytes, it streams 12h.
- R10: While hold_n is low, io_oe is 2'b00 and bus-clock edges are ignored. The transfer resumes where it stopped once hold_n is high again.
- R11: Select rising at any point aborts the frame, and the next frame is decoded from its first bit.
- R12: After reset, io_oe is 2'b00, power_down is 0 and no request is issued.
- R13: An opcode not listed here makes the rest of the frame ignored, with io_oe 2'b00 and no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial bus clock |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Pause input, active low |
| si | input | 1 | Serial data in (IO0) |
| io_out | output | 2 | [1] serial out / upper dual bit, [0] lower dual bit |
| io_oe | output | 2 | Output enables for io_out |
| mem_req | output | 1 | Array read request, one clock |
| mem_addr | output | MEM_AW | Array read address |
| mem_rdata | input | 8 | Array data, valid one clock after mem_req |
| stat_req | output | 1 | Status byte request, one clock |
| stat_rdata | input | 8 | Status byte |
| power_down | output | 1 | Deep-sleep state |

## Verification
The bench goes after the address wrap at the array top; a design that carries into unused address bits would return the wrong byte after the last location. It runs the don't-care byte of the fast reads, where an off-by-eight header shifts every byte, and the dual bit pairing, where swapped lanes scramble the data. It also checks the ID stream's starting parity and repeat. It pauses the bus mid-stream and aborts a frame mid-header, which catches counters that keep running or never clear. Deep sleep is checked for ignored reads and for a wake that lands on the programmed cycle count and not at once.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [1:0] {ST_CMD, ST_HDR, ST_DATA, ST_SKIP} spf_state_e;
  typedef enum logic [2:0] {SRC_MEM, SRC_STAT, SRC_JID, SRC_RID, SRC_SIG} spf_src_e;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_DREAD = 8'h3B;
  localparam logic [7:0] OP_JID   = 8'h9F;
  localparam logic [7:0] OP_RID   = 8'h90;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;

  localparam logic [7:0] ID_MFR  = 8'h8C;
  localparam logic [7:0] ID_TYPE = 8'h30;
  localparam logic [7:0] ID_JDEV = 8'h13;
  localparam logic [7:0] ID_DEV  = 8'h12;
endpackage

// File: rtl/spf_edge.sv
module spf_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  output logic rise,
  output logic fall,
  output logic cs_end
);
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign rise   = sck & ~sck_q & ~cs_n & hold_n;
  assign fall   = ~sck & sck_q & ~cs_n & hold_n;
  assign cs_end = cs_n & ~cs_q;
endmodule

// File: rtl/spf_tx.sv
module spf_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       shift,
  input  logic       dual,
  output logic [1:0] bits,
  output logic       last
);
  logic [7:0] sr_q;
  logic [2:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      bits  <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      bits  <= '0;
    end else if (load) begin
      sr_q  <= load_byte;
      cnt_q <= '0;
    end else if (shift) begin
      if (dual) begin
        bits  <= sr_q[7:6];
        sr_q  <= {sr_q[5:0], 2'b00};
        cnt_q <= cnt_q + 3'd2;
      end else begin
        bits  <= {sr_q[7], 1'b0};
        sr_q  <= {sr_q[6:0], 1'b0};
        cnt_q <= cnt_q + 3'd1;
      end
    end
  end

  assign last = dual ? (cnt_q == 3'd6) : (cnt_q == 3'd7);

  // Dual lanes always move in bit pairs (R4)
  assert_dual_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && !clr) |-> !cnt_q[0]);
endmodule

// File: rtl/spf_front.sv
module spf_front #(
  parameter int MEM_AW      = 10,
  parameter int WAKE_CYCLES = 64,
  localparam int WAKE_W     = $clog2(WAKE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              si,
  output logic [1:0]        io_out,
  output logic [1:0]        io_oe,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              stat_req,
  input  logic [7:0]        stat_rdata,
  output logic              power_down
);
  import spf_pkg::*;

  logic rst_r1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_r1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_r1 <= 1'b1;
      rst_s  <= rst_r1;
    end
  end

  logic rise, fall, cs_end, tx_last;
  spf_edge u_edge (.clk(clk), .rst_n(rst_s), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
                   .rise(rise), .fall(fall), .cs_end(cs_end));

  spf_state_e        state_q, state_n;
  spf_src_e          src_q, src_n;
  logic [5:0]        cnt_q, cnt_n, hdr_len_q, hdr_len_n;
  logic [6:0]        cmd_q, cmd_n;
  logic [MEM_AW-1:0] addr_q, addr_n, ptr_q, ptr_n;
  logic [1:0]        idx_q, idx_n;
  logic [7:0]        byte_q, byte_n, op;
  logic              dual_q, dual_n, load_q, fetch;
  logic              dpd_q, dpd_n, enter_q, enter_n, arm_q, arm_n, wake_q, wake_n;
  logic [WAKE_W-1:0] wcnt_q, wcnt_n;

  assign op = {cmd_q, si};

  always_comb begin
    state_n = state_q;  src_n  = src_q;  cnt_n  = cnt_q;  hdr_len_n = hdr_len_q;
    cmd_n   = cmd_q;    addr_n = addr_q; ptr_n  = ptr_q;  idx_n     = idx_q;
    byte_n  = byte_q;   dual_n = dual_q; fetch  = 1'b0;
    dpd_n   = dpd_q;    enter_n = enter_q; arm_n = arm_q; wake_n = wake_q; wcnt_n = wcnt_q;
    mem_req = 1'b0;     stat_req = 1'b0; mem_addr = ptr_q;

    if (cs_n) begin
      state_n = ST_CMD;
      cnt_n   = '0;
    end else begin
      case (state_q)
        ST_CMD: if (rise) begin
          cmd_n = op[6:0];
          cnt_n = cnt_q + 6'd1;
          if (cnt_q == 6'd7) begin
            cnt_n = '0;  dual_n = 1'b0;  hdr_len_n = 6'd24;  state_n = ST_HDR;
            if (dpd_q && op != OP_WAKE) state_n = ST_SKIP;
            else begin
              case (op)
                OP_READ:  src_n = SRC_MEM;
                OP_FREAD: begin src_n = SRC_MEM; hdr_len_n = 6'd32; end
                OP_DREAD: begin src_n = SRC_MEM; hdr_len_n = 6'd32; dual_n = 1'b1; end
                OP_RID:   src_n = SRC_RID;
                OP_WAKE:  begin src_n = SRC_SIG; arm_n = 1'b1; end
                OP_JID:   begin src_n = SRC_JID; idx_n = '0; state_n = ST_DATA; fetch = 1'b1; end
                OP_STAT:  begin src_n = SRC_STAT; state_n = ST_DATA; fetch = 1'b1; end
                OP_SLEEP: begin enter_n = 1'b1; state_n = ST_SKIP; end
                default:  state_n = ST_SKIP;
              endcase
            end
          end
        end
        ST_HDR: if (rise) begin
          cnt_n = cnt_q + 6'd1;
          if (cnt_q < 6'd24) addr_n = {addr_q[MEM_AW-2:0], si};
          if (cnt_q == hdr_len_q - 6'd1) begin
            state_n = ST_DATA;
            fetch   = 1'b1;
            ptr_n   = addr_n;
            idx_n   = '0;
          end
        end
        ST_DATA: if (fall && tx_last) fetch = 1'b1;
        default: ;
      endcase
    end

    if (fetch) begin
      case (src_n)
        SRC_MEM:  begin mem_req = 1'b1; mem_addr = ptr_n; ptr_n = ptr_n + 1'b1; end
        SRC_STAT: begin stat_req = 1'b1; byte_n = stat_rdata; end
        SRC_JID:  begin
          byte_n = (idx_n == 2'd0) ? ID_MFR : (idx_n == 2'd1) ? ID_TYPE : ID_JDEV;
          idx_n  = (idx_n == 2'd2) ? 2'd0 : idx_n + 2'd1;
        end
        SRC_RID:  begin byte_n = ptr_n[0] ? ID_DEV : ID_MFR; ptr_n = ptr_n + 1'b1; end
        default:  byte_n = ID_DEV;
      endcase
    end

    if (wake_q) begin
      wcnt_n = wcnt_q + 1'b1;
      if (wcnt_q == WAKE_W'(WAKE_CYCLES - 1)) begin
        dpd_n  = 1'b0;
        wake_n = 1'b0;
      end
    end
    if (cs_end) begin
      if (enter_q) dpd_n = 1'b1;
      if (arm_q && dpd_q) begin
        wake_n = 1'b1;
        wcnt_n = '0;
      end
      enter_n = 1'b0;
      arm_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_CMD;  src_q  <= SRC_MEM; cnt_q  <= '0; hdr_len_q <= 6'd24;
      cmd_q   <= '0;      addr_q <= '0;      ptr_q  <= '0; idx_q     <= '0;
      byte_q  <= '0;      dual_q <= 1'b0;    load_q <= 1'b0;
      dpd_q   <= 1'b0;    enter_q <= 1'b0;   arm_q  <= 1'b0; wake_q <= 1'b0; wcnt_q <= '0;
    end else begin
      state_q <= state_n; src_q  <= src_n;   cnt_q  <= cnt_n; hdr_len_q <= hdr_len_n;
      cmd_q   <= cmd_n;   addr_q <= addr_n;  ptr_q  <= ptr_n; idx_q     <= idx_n;
      byte_q  <= byte_n;  dual_q <= dual_n;  load_q <= fetch;
      dpd_q   <= dpd_n;   enter_q <= enter_n; arm_q <= arm_n; wake_q <= wake_n; wcnt_q <= wcnt_n;
    end
  end

  spf_tx u_tx (.clk(clk), .rst_n(rst_s), .clr(cs_n), .load(load_q),
               .load_byte((src_q == SRC_MEM) ? mem_rdata : byte_q),
               .shift(fall && state_q == ST_DATA), .dual(dual_q),
               .bits(io_out), .last(tx_last));

  assign io_oe[1]   = (state_q == ST_DATA) && !cs_n && hold_n;
  assign io_oe[0]   = io_oe[1] && dual_q;
  assign power_down = dpd_q;

  // Sleep blocks array traffic (R8)
  assert_sleep_no_mem_R8: assert property (@(posedge clk) disable iff (!rst_s)
    dpd_q |-> !mem_req);
  // Sleep is entered only on a select rise (R8)
  assert_sleep_on_cs_R8: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(dpd_q) |-> $past(cs_n));
  // Select high returns the decoder to the opcode phase (R11)
  assert_cs_idle_R11: assert property (@(posedge clk) disable iff (!rst_s)
    $past(cs_n) |-> state_q == ST_CMD);
  // At most one byte source is asked per clock (R7)
  assert_one_req_R7: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({mem_req, stat_req}));
  // A paused bus holds its output bits (R10)
  assert_hold_frozen_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (!hold_n && !cs_n) |=> $stable(io_out));
endmodule

// File: tb/spf_front_tb.sv
module spf_front_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;
  localparam int AW    = 10;
  localparam int WAKE  = 20;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic [1:0] io_out, io_oe;
  logic mem_req, stat_req, power_down;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] stat_rdata = 8'hA5;
  int n_chk = 0, n_err = 0, mem_cnt = 0, stat_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  spf_front #(.MEM_AW(AW), .WAKE_CYCLES(WAKE)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .io_out(io_out), .io_oe(io_oe), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .stat_req(stat_req), .stat_rdata(stat_rdata),
    .power_down(power_down));

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= mem_addr[7:0] + 8'h11;
      mem_cnt   <= mem_cnt + 1;
    end
    if (stat_req) stat_cnt <= stat_cnt + 1;
  end

  // op, addr, idle-high clock, three expected bytes
  localparam logic [56:0] VECS [0:8] = '{
    {8'h03, 24'h000010, 1'b0, 24'h212223},
    {8'h03, 24'h0003FF, 1'b1, 24'h101112},
    {8'h0B, 24'h000020, 1'b0, 24'h313233},
    {8'h3B, 24'h000005, 1'b1, 24'h161718},
    {8'h9F, 24'h000000, 1'b0, 24'h8C3013},
    {8'h90, 24'h000000, 1'b1, 24'h8C128C},
    {8'h90, 24'h000001, 1'b0, 24'h128C12},
    {8'h05, 24'h000000, 1'b0, 24'hA5A5A5},
    {8'hAB, 24'h000000, 1'b0, 24'h121212}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_frame(input bit m3);
    sck = m3; tick(2); cs_n = 1'b0; tick(2);
  endtask

  task automatic end_frame(input bit m3);
    sck = m3; tick(HALF); cs_n = 1'b1; si = 1'b0; tick(4);
  endtask

  task automatic xfer(input logic [7:0] tx, input bit dual, output logic [7:0] rx);
    rx = '0;
    if (dual) begin
      for (int i = 0; i < 4; i++) begin
        sck = 1'b0; tick(HALF); rx = {rx[5:0], io_out};
        sck = 1'b1; tick(HALF);
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        sck = 1'b0; tick(HALF); rx = {rx[6:0], io_out[1]};
        si = tx[7-i]; sck = 1'b1; tick(HALF);
      end
    end
  endtask

  task automatic send_hdr(input logic [23:0] a, input int nbytes);
    logic [7:0] d;
    for (int b = 0; b < nbytes; b++) begin
      if (b < 3) xfer(a[23-8*b -: 8], 1'b0, d);
      else       xfer(8'h00, 1'b0, d);
    end
  endtask

  function automatic int hdr_of(input logic [7:0] op);
    if (op == 8'h03 || op == 8'h90 || op == 8'hAB) return 3;
    if (op == 8'h0B || op == 8'h3B) return 4;
    return 0;
  endfunction

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h03: return "R2";
      8'h0B: return "R3";
      8'h3B: return "R4";
      8'h9F: return "R5";
      8'h90: return "R6";
      8'h05: return "R7";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int m0, s0;
    tick(3); rst_n = 1'b1; tick(4);
    chk("R12 oe", 32'(io_oe), 32'h0);
    chk("R12 sleep", 32'(power_down), 32'h0);
    chk("R12 req", 32'(mem_cnt + stat_cnt), 32'h0);

    for (int v = 0; v < 9; v++) begin
      logic [7:0] op;
      logic [23:0] ad, ex;
      bit m3;
      op = VECS[v][56:49]; ad = VECS[v][48:25]; m3 = VECS[v][24]; ex = VECS[v][23:0];
      start_frame(m3);
      xfer(op, 1'b0, r);
      send_hdr(ad, hdr_of(op));
      for (int k = 0; k < 3; k++) begin
        xfer(8'h00, op == 8'h3B, r);
        chk(m3 ? {"R1/", req_of(op)} : req_of(op), 32'(r), 32'(ex[23-8*k -: 8]));
      end
      chk({req_of(op), " oe"}, 32'(io_oe), (op == 8'h3B) ? 32'h3 : 32'h2);
      end_frame(m3);
    end

    // R5: ID stream repeats after the third byte
    start_frame(0); xfer(8'h9F, 0, r);
    for (int k = 0; k < 4; k++) xfer(8'h00, 0, r);
    chk("R5 repeat", 32'(r), 32'h8C);
    end_frame(0);

    // R7: status requests issued one byte ahead
    s0 = stat_cnt;
    start_frame(0); xfer(8'h05, 0, r); xfer(8'h00, 0, r); xfer(8'h00, 0, r);
    chk("R7 req count", 32'(stat_cnt - s0), 32'd3);
    end_frame(0);

    // R11: abort inside the address, then a fresh frame
    start_frame(0); xfer(8'h03, 0, r); xfer(8'h00, 0, r); end_frame(0);
    start_frame(0); xfer(8'h9F, 0, r); xfer(8'h00, 0, r);
    chk("R11 after abort", 32'(r), 32'h8C);
    end_frame(0);

    // R13: unknown opcode ignored
    m0 = mem_cnt;
    start_frame(0); xfer(8'h77, 0, r); xfer(8'h00, 0, r);
    chk("R13 oe", 32'(io_oe), 32'h0);
    xfer(8'h00, 0, r);
    chk("R13 req", 32'(mem_cnt - m0), 32'h0);
    end_frame(0);

    // R10: pause during the data stream
    start_frame(0); xfer(8'h03, 0, r); send_hdr(24'h000040, 3);
    xfer(8'h00, 0, r);
    chk("R10 before pause", 32'(r), 32'h51);
    hold_n = 1'b0; tick(2);
    chk("R10 oe in pause", 32'(io_oe), 32'h0);
    for (int t = 0; t < 3; t++) begin sck = 1'b0; tick(HALF); sck = 1'b1; tick(HALF); end
    hold_n = 1'b1; tick(2);
    xfer(8'h00, 0, r);
    chk("R10 resume", 32'(r), 32'h52);
    end_frame(0);

    // R8: deep sleep blocks reads
    start_frame(0); xfer(8'hB9, 0, r); end_frame(0);
    chk("R8 entered", 32'(power_down), 32'h1);
    m0 = mem_cnt;
    start_frame(0); xfer(8'h03, 0, r); send_hdr(24'h000000, 3); xfer(8'h00, 0, r);
    chk("R8 oe", 32'(io_oe), 32'h0);
    chk("R8 req", 32'(mem_cnt - m0), 32'h0);
    end_frame(0);
    chk("R8 still asleep", 32'(power_down), 32'h1);

    // R9: wake after the programmed delay
    start_frame(0); xfer(8'hAB, 0, r); end_frame(0);
    tick(WAKE - 8);
    chk("R9 not yet awake", 32'(power_down), 32'h1);
    tick(8);
    chk("R9 awake", 32'(power_down), 32'h0);
    start_frame(0); xfer(8'h03, 0, r); send_hdr(24'h000007, 3); xfer(8'h00, 0, r);
    chk("R9 read after wake", 32'(r), 32'h18);
    end_frame(0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule